// File: doc/BRIEF.md
# Line Sync Error Rate Monitor

This block watches a video receiver's per-line sync verdicts and raises a warning when lines with a bad or absent sync arrive too often. The line is framed by a single-cycle tick at its end. During the line, the upstream sync detector may pulse a "sync good" strobe, a "sync bad" strobe, both, or neither. At the tick the line is judged. It is bad if any bad strobe was seen, or if no good strobe was seen. A line with no sync at all is therefore an error, just like a misplaced one.

Each judged line feeds a digital leaky accumulator in place of an analog RC integrator. A bad line adds a fixed weight and every line drains a fixed decay, with saturation at zero and at a ceiling. A hysteresis comparator turns the level into an active-high warning flag. The flag sets at or above an upper threshold, clears at or below a lower one, and holds in between. With the defaults (weight 10, decay 1) a steady rate of one bad line in ten keeps the level flat near zero, while faster error rates climb to the set threshold. The flag drops by itself once the error rate falls off. All inputs and the output are plain control pins; there is no data stream and no back-pressure.

Top module: `sync_rate_mon`

## Requirements
- R1: After reset the accumulator level is 0 and `warn_flag` is low.
- R2: A line closes on the cycle `line_tick` is high. It is bad if `sync_err` was high on any cycle since the previous tick, this tick cycle included, or if `sync_ok` was high on none of those cycles. A line counts at most once, whatever number of strobes it carries.
- R3: Strobes without a `line_tick` change neither the accumulator nor `warn_flag`; they only take part in judging the line that the next tick closes.
- R4: On each closed line the level becomes level + WEIGHT (bad line only) − DECAY, floored at 0. The defaults are WEIGHT = 10 and DECAY = 1.
- R5: The level saturates at ACC_MAX (default 63) and never wraps.
- R6: When the level is at or above SET_TH (default 40), `warn_flag` is high on the next cycle. The flag reflects a closed line two clock cycles after the tick cycle.
- R7: When the level is at or below CLR_TH (default 20), `warn_flag` is low on the next cycle.
- R8: When the level lies strictly between CLR_TH and SET_TH, `warn_flag` keeps its value.
- R9: With the defaults, one bad line in every ten never raises the flag, and one bad line in every five does raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_tick | input | 1 | One-cycle pulse at the end of each line |
| sync_ok | input | 1 | Pulse: sync found at its expected place in the current line |
| sync_err | input | 1 | Pulse: sync found misplaced or corrupted in the current line |
| warn_flag | output | 1 | Active-high error rate warning |

## Verification
The bench drives bursts of bad lines to reach the set threshold exactly. It then drains with good lines to reach the clear threshold exactly, so an off-by-one comparator moves the flag one line early or late. Saturation is probed from both sides. After a long bad run, a wrapping ceiling would make the flag drop too soon. After a long good run, a wrapping floor would raise it at once. Lines with no sync at all, and lines whose only good strobe lands on the tick cycle, separate a detector that misjudges line boundaries from a correct one. A long flood of bad strobes with no tick shows whether errors are counted per line or per strobe. The one-in-ten and one-in-five patterns check that the defaults give the intended rate.

// File: rtl/srm_pkg.sv
package srm_pkg;
  // Verdict for one closed line, produced by the line judge.
  typedef struct packed {
    logic done;  // one-cycle pulse: a line just closed
    logic bad;   // that line had an error or no sync at all
  } line_verdict_t;
endpackage

// File: rtl/srm_line_judge.sv
module srm_line_judge
  import srm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_tick,
  input  logic          sync_ok,
  input  logic          sync_err,
  output line_verdict_t verdict
);
  logic ok_seen_q, err_seen_q;
  logic done_q, bad_q;
  logic ok_any, err_any;

  // Strobes on the tick cycle belong to the line being closed (R2).
  assign ok_any  = ok_seen_q | sync_ok;
  assign err_any = err_seen_q | sync_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_seen_q  <= 1'b0;
      err_seen_q <= 1'b0;
      done_q     <= 1'b0;
      bad_q      <= 1'b0;
    end else begin
      done_q <= line_tick;
      if (line_tick) begin
        bad_q      <= err_any | ~ok_any;
        ok_seen_q  <= 1'b0;
        err_seen_q <= 1'b0;
      end else begin
        ok_seen_q  <= ok_any;
        err_seen_q <= err_any;
      end
    end
  end

  assign verdict.done = done_q;
  assign verdict.bad  = bad_q;
endmodule

// File: rtl/srm_leaky_acc.sv
module srm_leaky_acc
  import srm_pkg::*;
#(
  parameter int ACC_MAX = 63,
  parameter int WEIGHT  = 10,
  parameter int DECAY   = 1,
  localparam int ACC_W  = $clog2(ACC_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  line_verdict_t    verdict,
  output logic [ACC_W-1:0] level
);
  localparam int SUM_W = $clog2(ACC_MAX + WEIGHT + 1) + 1;
  localparam logic [SUM_W-1:0] W_S = SUM_W'(WEIGHT);
  localparam logic [SUM_W-1:0] D_S = SUM_W'(DECAY);
  localparam logic [SUM_W-1:0] M_S = SUM_W'(ACC_MAX);

  logic [ACC_W-1:0] level_q;
  logic [SUM_W-1:0] raised, lowered, nxt;

  always_comb begin
    raised = SUM_W'(level_q) + (verdict.bad ? W_S : '0);
    if (raised < D_S) lowered = '0;
    else              lowered = raised - D_S;
    if (lowered > M_S) nxt = M_S;
    else               nxt = lowered;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           level_q <= '0;
    else if (verdict.done) level_q <= ACC_W'(nxt);
  end

  assign level = level_q;
endmodule

// File: rtl/srm_hyst_flag.sv
module srm_hyst_flag #(
  parameter int ACC_W  = 6,
  parameter int SET_TH = 40,
  parameter int CLR_TH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] level,
  output logic             flag
);
  localparam logic [ACC_W-1:0] SET_V = ACC_W'(SET_TH);
  localparam logic [ACC_W-1:0] CLR_V = ACC_W'(CLR_TH);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              flag_q <= 1'b0;
    else if (level >= SET_V) flag_q <= 1'b1;
    else if (level <= CLR_V) flag_q <= 1'b0;
  end

  assign flag = flag_q;
endmodule

// File: rtl/sync_rate_mon.sv
module sync_rate_mon
  import srm_pkg::*;
#(
  parameter int ACC_MAX = 63,
  parameter int WEIGHT  = 10,
  parameter int DECAY   = 1,
  parameter int SET_TH  = 40,
  parameter int CLR_TH  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_tick,
  input  logic sync_ok,
  input  logic sync_err,
  output logic warn_flag
);
  localparam int ACC_W = $clog2(ACC_MAX + 1);

  line_verdict_t    line_v;
  logic [ACC_W-1:0] acc_level;

  srm_line_judge u_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_tick (line_tick),
    .sync_ok   (sync_ok),
    .sync_err  (sync_err),
    .verdict   (line_v)
  );

  srm_leaky_acc #(
    .ACC_MAX (ACC_MAX),
    .WEIGHT  (WEIGHT),
    .DECAY   (DECAY)
  ) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .verdict (line_v),
    .level   (acc_level)
  );

  srm_hyst_flag #(
    .ACC_W  (ACC_W),
    .SET_TH (SET_TH),
    .CLR_TH (CLR_TH)
  ) u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .level (acc_level),
    .flag  (warn_flag)
  );
endmodule

// File: rtl/sync_rate_mon_chk.sv
module sync_rate_mon_chk #(
  parameter int ACC_MAX = 63,
  parameter int WEIGHT  = 10,
  parameter int DECAY   = 1,
  parameter int SET_TH  = 40,
  parameter int CLR_TH  = 20,
  localparam int ACC_W  = $clog2(ACC_MAX + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_done,
  input logic             line_bad,
  input logic [ACC_W-1:0] level,
  input logic             warn_flag
);
  localparam logic [ACC_W-1:0] SET_V = ACC_W'(SET_TH);
  localparam logic [ACC_W-1:0] CLR_V = ACC_W'(CLR_TH);

  // R3: level moves only on a closed line
  a_r3_level_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !line_done |=> $stable(level));

  // R4: a good line never raises the level
  a_r4_good_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (line_done && !line_bad) |=> (level <= $past(level)));

  generate
    if (WEIGHT > DECAY) begin : g_rise
      localparam logic [ACC_W-1:0] ROOM_V = ACC_W'(ACC_MAX - (WEIGHT - DECAY));
      // R4: a bad line raises the level while headroom remains
      a_r4_bad_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (line_done && line_bad && level <= ROOM_V) |=> (level > $past(level)));
    end
  endgenerate

  // R6: set threshold raises the flag
  a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
    (level >= SET_V) |=> warn_flag);

  // R7: clear threshold lowers the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (level <= CLR_V) |=> !warn_flag);

  // R8: between thresholds the flag holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (level > CLR_V && level < SET_V) |=> $stable(warn_flag));
endmodule

bind sync_rate_mon sync_rate_mon_chk #(
  .ACC_MAX (ACC_MAX),
  .WEIGHT  (WEIGHT),
  .DECAY   (DECAY),
  .SET_TH  (SET_TH),
  .CLR_TH  (CLR_TH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_done (line_v.done),
  .line_bad  (line_v.bad),
  .level     (acc_level),
  .warn_flag (warn_flag)
);

// File: tb/sync_rate_mon_tb.sv
module sync_rate_mon_tb;
  localparam int ACC_MAX = 63;
  localparam int WEIGHT  = 10;
  localparam int DECAY   = 1;
  localparam int SET_TH  = 40;
  localparam int CLR_TH  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_tick = 1'b0;
  logic sync_ok = 1'b0;
  logic sync_err = 1'b0;
  logic warn_flag;

  int n_checks = 0;
  int n_fail = 0;
  int exp_acc = 0;
  bit exp_flag = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sync_rate_mon #(
    .ACC_MAX (ACC_MAX), .WEIGHT (WEIGHT), .DECAY (DECAY),
    .SET_TH (SET_TH), .CLR_TH (CLR_TH)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .line_tick (line_tick),
    .sync_ok (sync_ok), .sync_err (sync_err), .warn_flag (warn_flag)
  );

  task automatic check_flag(input string tag, input bit exp);
    n_checks++;
    if (warn_flag !== exp) begin
      n_fail++;
      $display("FAIL %s: warn_flag=%0b expected=%0b (model level %0d)",
               tag, warn_flag, exp, exp_acc);
    end
  endtask

  // Model of R4/R5/R6/R7/R8 for one closed line.
  task automatic model_line(input bit bad);
    int v;
    v = exp_acc + (bad ? WEIGHT : 0);
    v = (v < DECAY) ? 0 : v - DECAY;
    if (v > ACC_MAX) v = ACC_MAX;
    exp_acc = v;
    if (exp_acc >= SET_TH) exp_flag = 1'b1;
    else if (exp_acc <= CLR_TH) exp_flag = 1'b0;
  endtask

  // One line: strobes, gap, tick (optional ok on tick cycle), settle.
  task automatic do_line(input bit ok, input bit err, input bit ok_at_tick);
    @(negedge clk);
    sync_ok = ok; sync_err = err;
    @(negedge clk);
    sync_ok = 1'b0; sync_err = 1'b0;
    @(negedge clk);
    line_tick = 1'b1; sync_ok = ok_at_tick;
    @(negedge clk);
    line_tick = 1'b0; sync_ok = 1'b0;
    repeat (3) @(negedge clk);
    model_line(err || !(ok || ok_at_tick));
  endtask

  task automatic good_lines(input int n, input string tag, input bit chk_each);
    for (int i = 0; i < n; i++) begin
      do_line(1'b1, 1'b0, 1'b0);
      if (chk_each) check_flag(tag, exp_flag);
    end
  endtask

  task automatic bad_lines(input int n, input string tag, input bit chk_each);
    for (int i = 0; i < n; i++) begin
      do_line(1'b1, 1'b1, 1'b0);
      if (chk_each) check_flag(tag, exp_flag);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check_flag("R1 flag low in reset", 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_flag("R1 flag low after reset", 1'b0);
  endtask

  task automatic t_burst_set;
    good_lines(20, "R4 good lines keep flag low", 1'b0);
    check_flag("R4 good lines keep flag low", 1'b0);
    bad_lines(4, "R6 below set", 1'b0);
    check_flag("R6 level 36 below set", 1'b0);
    bad_lines(1, "R6", 1'b0);
    check_flag("R6 level 45 sets flag", 1'b1);
  endtask

  task automatic t_hold_clear;
    good_lines(24, "R8 hold between thresholds", 1'b1);
    check_flag("R8 level 21 still high", 1'b1);
    good_lines(1, "R7", 1'b0);
    check_flag("R7 level 20 clears flag", 1'b0);
  endtask

  task automatic t_line_judge;
    // level 20: missing sync, ok only on tick, ok+err, err only
    do_line(1'b0, 1'b0, 1'b0);
    check_flag("R2 missing sync is bad (29)", exp_flag);
    do_line(1'b0, 1'b0, 1'b1);
    check_flag("R2 ok on tick cycle is good (28)", exp_flag);
    do_line(1'b1, 1'b1, 1'b0);
    check_flag("R2 ok plus err is bad (37)", exp_flag);
    do_line(1'b0, 1'b1, 1'b0);
    check_flag("R2 err only is bad (46)", 1'b1);
    good_lines(26, "R7", 1'b0);
    check_flag("R7 drained to 20", 1'b0);
  endtask

  task automatic t_flood;
    @(negedge clk);
    sync_err = 1'b1;
    repeat (60) @(negedge clk);
    sync_err = 1'b0;
    repeat (3) @(negedge clk);
    check_flag("R3 strobes without tick leave flag low", 1'b0);
    line_tick = 1'b1;
    @(negedge clk);
    line_tick = 1'b0;
    repeat (3) @(negedge clk);
    model_line(1'b1);
    check_flag("R2 flooded line counts once (29)", 1'b0);
    bad_lines(2, "R2", 1'b0);
    check_flag("R2 two more bad lines reach 47", 1'b1);
  endtask

  task automatic t_saturate;
    bad_lines(10, "R5", 1'b0);
    check_flag("R5 saturated high", 1'b1);
    good_lines(42, "R5", 1'b0);
    check_flag("R5 level 21 after ceiling", 1'b1);
    good_lines(1, "R5", 1'b0);
    check_flag("R5 level 20 after ceiling clears", 1'b0);
  endtask

  task automatic t_floor;
    good_lines(40, "R4 floor", 1'b0);
    check_flag("R4 floor at zero flag low", 1'b0);
    bad_lines(4, "R4 floor", 1'b0);
    check_flag("R4 from zero 36 no flag", 1'b0);
    bad_lines(1, "R4 floor", 1'b0);
    check_flag("R4 from zero 45 flags", 1'b1);
    good_lines(60, "R4", 1'b0);
  endtask

  task automatic t_rate;
    for (int p = 0; p < 10; p++) begin
      bad_lines(1, "R9 one in ten stays low", 1'b1);
      good_lines(9, "R9 one in ten stays low", 1'b1);
    end
    check_flag("R9 one in ten never flags", 1'b0);
    for (int p = 0; p < 10; p++) begin
      bad_lines(1, "R9 one in five", 1'b1);
      good_lines(4, "R9 one in five", 1'b1);
    end
    check_flag("R9 one in five flags", 1'b1);
  endtask

  initial begin
    t_reset();
    t_burst_set();
    t_hold_clear();
    t_line_judge();
    t_flood();
    t_saturate();
    t_floor();
    t_rate();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule